// File: doc/BRIEF.md
# Tiled View Address Generator

This block turns a pixel coordinate into an address in a tiled address space. The pixel format is one of four: 8-bit, 16-bit, 32-bit or page. The view orientation selects rotation and mirroring. The format and the orientation are both written into the upper address bits. Below them is a linear offset built from the two coordinates.

Mirroring inverts the active coordinate bits. Rotation by 90 or 270 degrees swaps the roles of X and Y in the offset. Each format drops low coordinate bits and shifts the offset left again, so wide pixels stay naturally aligned.

The block also reports the row stride that applies to the chosen format and orientation. A coordinate outside the active range produces a zero address and a deasserted valid flag. By default the result is registered one cycle after an input strobe. A parameter removes the register and makes the path purely combinational.

Top module: `tiled_view_addr`

## Requirements
- R1: Address bits [28:27] hold the format code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = page.
- R2: Address bits [31:29] repeat the 3-bit orientation input. Orientation bit 2 requests an X/Y swap, bit 1 inverts X and bit 0 inverts Y.
- R3: Each format drops bits from the coordinates. The pairs (X dropped, Y dropped) are (0,0) for 8-bit, (0,1) for 16-bit, (1,1) for 32-bit and (0,0) for page. The active X width is X_BITS minus the X drop, and the active Y width is Y_BITS minus the Y drop. A coordinate equal to its all-ones mask is still in range.
- R4: When an invert bit is set, that coordinate is XORed with the all-ones mask of its active width before the offset is formed.
- R5: Without a swap, the offset is (y << x_width) + x. With a swap, it is (x << y_width) + y. The offset is then shifted left by the sum of the two drops and placed zero-extended in bits [26:0].
- R6: If either coordinate exceeds its active mask, the address is 0 and out_valid stays low.
- R7: The stride is 1 << (Y_BITS + X drop) with a swap, and 1 << (X_BITS + Y drop) without one. It is reported even for out-of-range coordinates.
- R8: With the output register present, address and stride appear on the clock edge that samples in_valid high, and out_valid follows that strobe. In cycles without a strobe, out_valid is low and address and stride hold their values whatever the other inputs do.
- R9: Synchronous active-high reset clears out_valid, address and stride to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| fmt | input | 2 | Pixel format code |
| view | input | 3 | Orientation: swap, invert X, invert Y |
| x_coord | input | X_BITS | Pixel column |
| y_coord | input | Y_BITS | Pixel row |
| out_valid | output | 1 | Result valid, coordinate in range |
| addr | output | 32 | Tiled-space address |
| stride | output | max(X_BITS,Y_BITS)+2 | Row stride in bytes |

## Verification
The assertions assume that X_BITS plus Y_BITS is at most 27, so the offset fits below the format field. They also assume that reset is held for at least one clock edge before the first request. The stimulus uses a small geometry (4 X bits, 3 Y bits) that meets the width limit with room to spare. Reset is held for several cycles before any strobe. Between strobes, the stimulus drives junk coordinates so that the hold behaviour is tested against changing inputs.

// File: rtl/tva_pkg.sv
package tva_pkg;

    typedef enum logic [1:0] {
        FMT_B8   = 2'd0,
        FMT_B16  = 2'd1,
        FMT_B32  = 2'd2,
        FMT_PAGE = 2'd3
    } pix_fmt_e;

    typedef struct packed {
        logic swap_xy;
        logic flip_x;
        logic flip_y;
    } view_t;

    typedef struct packed {
        logic x_drop;
        logic y_drop;
    } geom_t;

    localparam int OFFSET_BITS = 27;

    function automatic geom_t fmt_geom(input pix_fmt_e f);
        geom_t g;
        case (f)
            FMT_B16: g = '{x_drop: 1'b0, y_drop: 1'b1};
            FMT_B32: g = '{x_drop: 1'b1, y_drop: 1'b1};
            default: g = '{x_drop: 1'b0, y_drop: 1'b0};
        endcase
        return g;
    endfunction

    function automatic int align_of(input geom_t g);
        return int'(g.x_drop) + int'(g.y_drop);
    endfunction

endpackage

// File: rtl/tva_geom.sv
module tva_geom
    import tva_pkg::*;
#(
    parameter int X_BITS = 14,
    parameter int Y_BITS = 13
) (
    input  pix_fmt_e          fmt,
    output geom_t             geom,
    output logic [X_BITS-1:0] x_mask,
    output logic [Y_BITS-1:0] y_mask
);

    always_comb begin
        geom   = fmt_geom(fmt);
        x_mask = {X_BITS{1'b1}} >> geom.x_drop;
        y_mask = {Y_BITS{1'b1}} >> geom.y_drop;
    end

endmodule

// File: rtl/tva_orient.sv
module tva_orient #(
    parameter int X_BITS = 14,
    parameter int Y_BITS = 13
) (
    input  logic [X_BITS-1:0] x_in,
    input  logic [Y_BITS-1:0] y_in,
    input  logic [X_BITS-1:0] x_mask,
    input  logic [Y_BITS-1:0] y_mask,
    input  logic              flip_x,
    input  logic              flip_y,
    output logic [X_BITS-1:0] x_eff,
    output logic [Y_BITS-1:0] y_eff,
    output logic              in_range
);

    logic x_ok, y_ok;

    always_comb begin
        x_ok     = ((x_in & ~x_mask) == '0);
        y_ok     = ((y_in & ~y_mask) == '0);
        in_range = x_ok & y_ok;
        x_eff    = flip_x ? (x_in ^ x_mask) : x_in;
        y_eff    = flip_y ? (y_in ^ y_mask) : y_in;
    end

endmodule

// File: rtl/tva_compose.sv
module tva_compose
    import tva_pkg::*;
#(
    parameter int X_BITS   = 14,
    parameter int Y_BITS   = 13,
    parameter int STRIDE_W = 16
) (
    input  logic [X_BITS-1:0]   x_eff,
    input  logic [Y_BITS-1:0]   y_eff,
    input  geom_t               geom,
    input  logic [1:0]          fmt_code,
    input  logic [2:0]          view_code,
    input  logic                in_range,
    output logic [31:0]         addr,
    output logic [STRIDE_W-1:0] stride
);

    localparam int OW = X_BITS + Y_BITS;

    logic [OW-1:0]       xw, yw, lin, aligned;
    logic [STRIDE_W-1:0] one;
    int                  x_width, y_width;

    always_comb begin
        xw      = OW'(x_eff);
        yw      = OW'(y_eff);
        x_width = X_BITS - int'(geom.x_drop);
        y_width = Y_BITS - int'(geom.y_drop);
        if (view_code[2])
            lin = (xw << y_width) | yw;
        else
            lin = (yw << x_width) | xw;
        aligned = lin << align_of(geom);
        addr    = in_range ? {view_code, fmt_code, OFFSET_BITS'(aligned)} : 32'd0;

        one = STRIDE_W'(1);
        if (view_code[2])
            stride = one << (Y_BITS + int'(geom.x_drop));
        else
            stride = one << (X_BITS + int'(geom.y_drop));
    end

endmodule

// File: rtl/tiled_view_addr.sv
module tiled_view_addr
    import tva_pkg::*;
#(
    parameter int  X_BITS   = 14,
    parameter int  Y_BITS   = 13,
    parameter bit  REG_OUT  = 1'b1,
    localparam int STRIDE_W = ((X_BITS > Y_BITS) ? X_BITS : Y_BITS) + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [1:0]          fmt,
    input  logic [2:0]          view,
    input  logic [X_BITS-1:0]   x_coord,
    input  logic [Y_BITS-1:0]   y_coord,
    output logic                out_valid,
    output logic [31:0]         addr,
    output logic [STRIDE_W-1:0] stride
);

    pix_fmt_e            fmt_e;
    view_t               view_s;
    geom_t               geom;
    logic [X_BITS-1:0]   x_mask, x_eff;
    logic [Y_BITS-1:0]   y_mask, y_eff;
    logic                in_range;
    logic [31:0]         addr_c;
    logic [STRIDE_W-1:0] stride_c;

    assign fmt_e  = pix_fmt_e'(fmt);
    assign view_s = view_t'(view);

    tva_geom #(.X_BITS(X_BITS), .Y_BITS(Y_BITS)) u_geom (
        .fmt    (fmt_e),
        .geom   (geom),
        .x_mask (x_mask),
        .y_mask (y_mask)
    );

    tva_orient #(.X_BITS(X_BITS), .Y_BITS(Y_BITS)) u_orient (
        .x_in     (x_coord),
        .y_in     (y_coord),
        .x_mask   (x_mask),
        .y_mask   (y_mask),
        .flip_x   (view_s.flip_x),
        .flip_y   (view_s.flip_y),
        .x_eff    (x_eff),
        .y_eff    (y_eff),
        .in_range (in_range)
    );

    tva_compose #(.X_BITS(X_BITS), .Y_BITS(Y_BITS), .STRIDE_W(STRIDE_W)) u_compose (
        .x_eff     (x_eff),
        .y_eff     (y_eff),
        .geom      (geom),
        .fmt_code  (fmt),
        .view_code (view),
        .in_range  (in_range),
        .addr      (addr_c),
        .stride    (stride_c)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_valid <= 1'b0;
                    addr      <= '0;
                    stride    <= '0;
                end else begin
                    out_valid <= in_valid & in_range;
                    if (in_valid) begin
                        addr   <= addr_c;
                        stride <= stride_c;
                    end
                end
            end
        end else begin : g_comb
            assign out_valid = in_valid & in_range;
            assign addr      = addr_c;
            assign stride    = stride_c;
        end
    endgenerate

endmodule

// File: rtl/tiled_view_addr_chk.sv
module tiled_view_addr_chk #(
    parameter int X_BITS   = 14,
    parameter int Y_BITS   = 13,
    parameter bit REG_OUT  = 1'b1,
    parameter int STRIDE_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [1:0]          fmt,
    input logic [2:0]          view,
    input logic                out_valid,
    input logic [31:0]         addr,
    input logic [STRIDE_W-1:0] stride
);

    logic live;

    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    generate
        if (REG_OUT) begin : g_props
            AST_FMT_FIELD: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> addr[28:27] == $past(fmt)); // R1
            AST_VIEW_FIELD: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> addr[31:29] == $past(view)); // R2
            AST_WIDE_ALIGN: assert property (@(posedge clk) disable iff (rst)
                (out_valid && addr[28:27] == 2'd2) |-> addr[1:0] == 2'd0); // R5
            AST_BAD_ZERO: assert property (@(posedge clk) disable iff (rst)
                (live && $past(in_valid) && !out_valid) |-> addr == 32'd0); // R6
            AST_STRIDE_POW2: assert property (@(posedge clk) disable iff (rst)
                (live && $past(in_valid)) |-> $countones(stride) == 1); // R7
            AST_VALID_STROBE: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> (live && $past(in_valid))); // R8
            AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
                (live && !$past(in_valid)) |-> ($stable(addr) && $stable(stride))); // R8
        end else begin : g_none
            always_comb begin
                AST_COMB_VALID: assert (!out_valid || in_valid); // R6
            end
        end
    endgenerate

endmodule

bind tiled_view_addr tiled_view_addr_chk #(
    .X_BITS   (X_BITS),
    .Y_BITS   (Y_BITS),
    .REG_OUT  (REG_OUT),
    .STRIDE_W (STRIDE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .fmt       (fmt),
    .view      (view),
    .out_valid (out_valid),
    .addr      (addr),
    .stride    (stride)
);

// File: tb/tiled_view_addr_tb.sv
module tiled_view_addr_tb;

    localparam int CLK_PERIOD = 10;
    localparam int XB = 4;
    localparam int YB = 3;
    localparam int SW = ((XB > YB) ? XB : YB) + 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    fmt = '0;
    logic [2:0]    view = '0;
    logic [XB-1:0] x_coord = '0;
    logic [YB-1:0] y_coord = '0;
    logic          out_valid;
    logic [31:0]   addr;
    logic [SW-1:0] stride;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tiled_view_addr #(.X_BITS(XB), .Y_BITS(YB)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .fmt       (fmt),
        .view      (view),
        .x_coord   (x_coord),
        .y_coord   (y_coord),
        .out_valid (out_valid),
        .addr      (addr),
        .stride    (stride)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic void model(input int f, input int v, input int x, input int y,
                                  output bit ok, output longint off, output int es);
        int xs, ys, xw, yw, xm, ym, xx, yy;
        xs = (f == 2) ? 1 : 0;
        ys = (f == 1 || f == 2) ? 1 : 0;
        xw = XB - xs;
        yw = YB - ys;
        xm = (1 << xw) - 1;
        ym = (1 << yw) - 1;
        ok = (x <= xm) && (y <= ym);
        xx = v[1] ? (x ^ xm) : x;
        yy = v[0] ? (y ^ ym) : y;
        if (v[2]) off = longint'(xx) * (longint'(1) << yw) + yy;
        else      off = longint'(yy) * (longint'(1) << xw) + xx;
        off = off << (xs + ys);
        es  = v[2] ? (1 << (YB + xs)) : (1 << (XB + ys));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog R8: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit     ok;
        longint off;
        int     es;
        logic [31:0]   held_addr;
        logic [SW-1:0] held_stride;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset out_valid", 64'(out_valid), 64'd0);
        check("R9 reset addr", 64'(addr), 64'd0);
        check("R9 reset stride", 64'(stride), 64'd0);

        for (int f = 0; f < 4; f++) begin
            for (int v = 0; v < 8; v++) begin
                for (int x = 0; x < (1 << XB); x++) begin
                    for (int y = 0; y < (1 << YB); y++) begin
                        @(negedge clk);
                        fmt      = 2'(f);
                        view     = 3'(v);
                        x_coord  = XB'(x);
                        y_coord  = YB'(y);
                        in_valid = 1'b1;
                        @(negedge clk);
                        in_valid = 1'b0;
                        x_coord  = ~x_coord;
                        y_coord  = ~y_coord;
                        view     = ~view;
                        model(f, v, x, y, ok, off, es);
                        check(ok ? "R3 in-range valid" : "R6 out-of-range valid",
                              64'(out_valid), 64'(ok));
                        if (ok) begin
                            check("R2 view field", 64'(addr[31:29]), 64'(v));
                            check("R1 format field", 64'(addr[28:27]), 64'(f));
                            check((v % 4 != 0) ? "R4 mirrored offset" : "R5 offset",
                                  64'(addr[26:0]), 64'(off));
                        end else begin
                            check("R6 zero address", 64'(addr), 64'd0);
                        end
                        check("R7 stride", 64'(stride), 64'(es));
                        held_addr   = addr;
                        held_stride = stride;
                        @(negedge clk);
                        check("R8 idle out_valid", 64'(out_valid), 64'd0);
                        check("R8 idle addr hold", 64'(addr), 64'(held_addr));
                        check("R8 idle stride hold", 64'(stride), 64'(held_stride));
                    end
                end
            end
        end

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 reset after traffic", 64'(addr), 64'd0);
        check("R9 reset after traffic out_valid", 64'(out_valid), 64'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule